// File: doc/BRIEF.md
# Tensor stream DMA engine

The engine moves a tensor between a memory-mapped AXI master and an AXI4-Stream port. The `TO_MEM` parameter picks the direction. With `TO_MEM = 0` it issues read bursts and forwards every returned beat onto the outbound stream. With `TO_MEM = 1` it takes beats from the inbound stream, issues write bursts, and waits for each write response before it goes on. A run is set up by a base address, a beat count per image and an image count, all sampled by a one-cycle start pulse. Every transfer is a whole number of data-bus words.

Two addressing policies are available. In the stepping policy (`wrap_mode = 0`), each image follows the previous one in memory. In the rewinding policy (`wrap_mode = 1`), each image starts again at the base address. The rewinding policy lets one buffer, such as a weight set, be streamed over and over. Bursts are cut at 256 beats and at every 4 KB page edge. The beat data path runs straight between the stream and the memory channel, so backpressure reaches across in the same cycle.

Top module: `stream_dma`

## Requirements
- R1: With TO_MEM=0, each read-data beat reaches m_data unchanged, in the order the memory returns it.
- R2: With TO_MEM=1, stream beats are written in arrival order to consecutive DATA_W/8-byte addresses, and w_last is high exactly on the final beat of each write burst.
- R3: With wrap_mode=0, beat j of image k (counting from 0) uses address base + (k*beats + j)*DATA_W/8.
- R4: With wrap_mode=1, beat j of every image uses address base + j*DATA_W/8.
- R5: A burst holds at most 256 beats and never crosses a 4096-byte boundary. A burst is shorter only when the image's remaining beats or the page edge force it, so the number of bursts is the smallest that these limits allow.
- R6: While an address request waits for ready, its valid stays high and its address and length do not change.
- R7: A beat moves only when both valid and ready are high on the stream side and on the memory side. Each run moves exactly beats*images beats.
- R8: done is a single-cycle pulse. It rises in the cycle after the last read beat's handshake (TO_MEM=0) or after the last write response's handshake (TO_MEM=1).
- R9: A start with an image count of 0 or a beat count of 0 raises done in the next cycle and issues no address.
- R10: A start pulse that arrives while a run is in progress is ignored.
- R11: After reset, done and all valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| base_addr | input | ADDR_W | Byte address of image data, aligned to DATA_W/8 |
| img_beats | input | BEAT_W | Data-bus words per image |
| img_count | input | REP_W | Number of images in the run |
| wrap_mode | input | 1 | 1: each image rewinds to base_addr; 0: addresses keep stepping |
| done | output | 1 | One-cycle end-of-run pulse |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | ADDR_W | Read burst start address |
| ar_len | output | 8 | Read burst beats minus one |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| r_data | input | DATA_W | Read data |
| r_last | input | 1 | Last read beat of a burst |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | ADDR_W | Write burst start address |
| aw_len | output | 8 | Write burst beats minus one |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | DATA_W | Write data |
| w_last | output | 1 | Last write beat of a burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |
| m_valid | output | 1 | Outbound stream valid |
| m_ready | input | 1 | Outbound stream ready |
| m_data | output | DATA_W | Outbound stream data |
| s_valid | input | 1 | Inbound stream valid |
| s_ready | output | 1 | Inbound stream ready |
| s_data | input | DATA_W | Inbound stream data |

## Verification
The assertions check several rules on every cycle: no burst crosses a page, no burst is longer than what is left of the image, an address request stays still while it is stalled, done lasts one cycle while no request is open, and an empty run finishes at once. Other behaviours show only in the bench scenarios, which run both directions side by side. These are the beat-by-beat address sequence under rewinding and stepping, the burst counts at page edges and at the 256-beat cut, the cycle done takes after the final read beat or the final write response, and that a start during a run is ignored.

// File: rtl/stream_dma.sv
module stream_dma #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 16,
  parameter int REP_W  = 16,
  parameter bit TO_MEM = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [BEAT_W-1:0] img_beats,
  input  logic [REP_W-1:0]  img_count,
  input  logic              wrap_mode,
  output logic              done,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic              r_last,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [7:0]        aw_len,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [DATA_W-1:0] w_data,
  output logic              w_last,
  input  logic              b_valid,
  output logic              b_ready,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data
);
  localparam int BPB       = DATA_W / 8;
  localparam int LOG_BPB   = $clog2(BPB);
  localparam int MAX_BURST = 256;

  typedef enum logic [1:0] {IDLE, ADDR, DATA, RESP} st_t;

  st_t               st;
  logic [ADDR_W-1:0] cur_addr, base_q;
  logic [BEAT_W-1:0] beats_q, beats_left;
  logic [REP_W-1:0]  reps_left;
  logic              wrap_q;
  logic [8:0]        burst_left, blen;
  logic [12:0]       room, room_beats;
  logic [7:0]        ax_len;
  logic              ax_valid, ax_ready, beat, burst_end, img_end;
  logic              unused_ok;

  assign room       = 13'd4096 - {1'b0, cur_addr[11:0]};
  assign room_beats = room >> LOG_BPB;

  always_comb begin
    blen = 9'd256;
    if (beats_left < BEAT_W'(MAX_BURST)) blen = beats_left[8:0];
    if (room_beats < {4'b0, blen}) blen = room_beats[8:0];
  end

  assign ax_len    = 8'(blen - 9'd1);
  assign ax_valid  = (st == ADDR);
  assign ax_ready  = TO_MEM ? aw_ready : ar_ready;
  assign beat      = (st == DATA) && (TO_MEM ? (s_valid && w_ready) : (r_valid && m_ready));
  assign burst_end = TO_MEM ? (st == RESP && b_valid) : (beat && burst_left == 9'd1);
  assign img_end   = (st == RESP) ? (beats_left == '0) : (beats_left == BEAT_W'(1));

  assign ar_valid = !TO_MEM && ax_valid;
  assign aw_valid = TO_MEM && ax_valid;
  assign ar_addr  = cur_addr;
  assign aw_addr  = cur_addr;
  assign ar_len   = ax_len;
  assign aw_len   = ax_len;
  assign r_ready  = !TO_MEM && (st == DATA) && m_ready;
  assign m_valid  = !TO_MEM && (st == DATA) && r_valid;
  assign m_data   = r_data;
  assign w_valid  = TO_MEM && (st == DATA) && s_valid;
  assign s_ready  = TO_MEM && (st == DATA) && w_ready;
  assign w_data   = s_data;
  assign w_last   = (burst_left == 9'd1);
  assign b_ready  = TO_MEM && (st == RESP);
  assign unused_ok = r_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      done       <= 1'b0;
      cur_addr   <= '0;
      base_q     <= '0;
      beats_q    <= '0;
      wrap_q     <= 1'b0;
      beats_left <= '0;
      reps_left  <= '0;
      burst_left <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          base_q     <= base_addr;
          beats_q    <= img_beats;
          wrap_q     <= wrap_mode;
          cur_addr   <= base_addr;
          beats_left <= img_beats;
          reps_left  <= img_count;
          if (img_count == '0 || img_beats == '0) done <= 1'b1;
          else st <= ADDR;
        end
        ADDR: if (ax_ready) begin
          burst_left <= blen;
          cur_addr   <= cur_addr + (ADDR_W'(blen) << LOG_BPB);
          st         <= DATA;
        end
        DATA: if (beat) begin
          burst_left <= burst_left - 9'd1;
          beats_left <= beats_left - BEAT_W'(1);
          if (TO_MEM && burst_left == 9'd1) st <= RESP;
        end
        default: ;
      endcase
      if (burst_end) begin
        if (!img_end) st <= ADDR;
        else if (reps_left == REP_W'(1)) begin
          st   <= IDLE;
          done <= 1'b1;
        end else begin
          reps_left  <= reps_left - REP_W'(1);
          beats_left <= beats_q;
          if (wrap_q) cur_addr <= base_q;
          st <= ADDR;
        end
      end
    end
  end

  // R5
  page_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid |-> (int'(cur_addr[11:0]) + ((int'(ax_len) + 1) << LOG_BPB)) <= 4096);

  // R5
  burst_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid |-> int'(ax_len) < int'(beats_left));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ax_valid && !ax_ready |=> ax_valid && $stable(cur_addr) && $stable(ax_len));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ax_valid && !m_valid && !w_valid);

  // R9
  empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && st == IDLE && (img_count == '0 || img_beats == '0) |=> done && !ax_valid);
endmodule

// File: tb/stream_dma_tb.sv
module stream_dma_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, arm = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_beats = '0, cfg_reps = '0;
  logic        cfg_wrap = 1'b0;
  logic        done_i, done_o;

  logic        ar_valid, ar_ready, r_valid, r_ready, r_last, m_valid, m_ready;
  logic [31:0] ar_addr, r_data, m_data;
  logic [7:0]  ar_len;
  logic        x_aw_valid, x_w_valid, x_w_last, x_b_ready, x_s_ready;
  logic [31:0] x_aw_addr, x_w_data;
  logic [7:0]  x_aw_len;

  logic        aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready, s_valid, s_ready;
  logic [31:0] aw_addr, w_data, s_data;
  logic [7:0]  aw_len;
  logic        y_ar_valid, y_r_ready, y_m_valid;
  logic [31:0] y_ar_addr, y_m_data;
  logic [7:0]  y_ar_len;

  stream_dma #(.TO_MEM(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(cfg_base), .img_beats(cfg_beats),
    .img_count(cfg_reps), .wrap_mode(cfg_wrap), .done(done_i),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_last(r_last),
    .aw_valid(x_aw_valid), .aw_ready(1'b0), .aw_addr(x_aw_addr), .aw_len(x_aw_len),
    .w_valid(x_w_valid), .w_ready(1'b0), .w_data(x_w_data), .w_last(x_w_last),
    .b_valid(1'b0), .b_ready(x_b_ready),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .s_valid(1'b0), .s_ready(x_s_ready), .s_data(32'h0));

  stream_dma #(.TO_MEM(1'b1)) u_dut_wr (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(cfg_base), .img_beats(cfg_beats),
    .img_count(cfg_reps), .wrap_mode(cfg_wrap), .done(done_o),
    .ar_valid(y_ar_valid), .ar_ready(1'b0), .ar_addr(y_ar_addr), .ar_len(y_ar_len),
    .r_valid(1'b0), .r_ready(y_r_ready), .r_data(32'h0), .r_last(1'b0),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready),
    .m_valid(y_m_valid), .m_ready(1'b0), .m_data(y_m_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data));

  // stimulus vectors: base, beats per image, images, rewind, expected bursts
  localparam int NV = 8;
  localparam logic [31:0] T_BASE [NV] = '{32'h1000, 32'h1000, 32'h1FF0, 32'h2000,
                                          32'h2000, 32'h0FF8, 32'h0FF8, 32'h5F00};
  localparam int T_BEATS  [NV] = '{8, 300, 10, 5, 5, 4, 4, 260};
  localparam int T_REPS   [NV] = '{1, 1, 1, 3, 3, 2, 2, 2};
  localparam bit T_WRAP   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam int T_BURSTS [NV] = '{1, 2, 2, 3, 3, 4, 3, 4};

  // memory and stream models
  int          pcyc;
  int          r_left, w_left, bdelay, rgap;
  logic [31:0] src_cnt;
  assign s_data = src_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcyc <= 0; ar_ready <= 1'b1; r_valid <= 1'b0; r_data <= '0; r_last <= 1'b0;
      r_left <= 0; rgap <= 0; m_ready <= 1'b0;
      aw_ready <= 1'b1; w_ready <= 1'b0; b_valid <= 1'b0; w_left <= 0; bdelay <= 0;
      s_valid <= 1'b0; src_cnt <= '0;
    end else begin
      pcyc    <= pcyc + 1;
      m_ready <= (pcyc % 3) != 0;
      s_valid <= (pcyc % 4) != 1;
      w_ready <= (pcyc % 5) != 2;
      if (ar_valid && ar_ready) begin
        ar_ready <= 1'b0; r_valid <= 1'b1; r_data <= ar_addr;
        r_left <= int'(ar_len) + 1; r_last <= (ar_len == 8'd0);
      end else if (r_valid && r_ready) begin
        if (r_left == 1) begin
          r_valid <= 1'b0; r_last <= 1'b0; rgap <= 3;
        end else begin
          r_left <= r_left - 1; r_data <= r_data + 32'd4; r_last <= (r_left == 2);
        end
      end else if (rgap > 1) rgap <= rgap - 1;
      else if (rgap == 1) begin
        rgap <= 0; ar_ready <= 1'b1;
      end
      if (s_valid && s_ready) src_cnt <= src_cnt + 32'd1;
      if (aw_valid && aw_ready) begin
        aw_ready <= 1'b0; w_left <= int'(aw_len) + 1;
      end
      if (w_valid && w_ready) begin
        w_left <= w_left - 1;
        if (w_left == 1) bdelay <= 3;
      end
      if (bdelay != 0) begin
        bdelay <= bdelay - 1;
        if (bdelay == 1) b_valid <= 1'b1;
      end
      if (b_valid && b_ready) begin
        b_valid <= 1'b0; aw_ready <= 1'b1;
      end
    end
  end

  // expected configuration, written only by the stimulus process
  logic [31:0] exp_base = '0;
  int          exp_beats = 1;
  bit          exp_wrap = 1'b0;

  function automatic logic [31:0] ea(int n);
    int k = exp_wrap ? (n % exp_beats) : n;
    return exp_base + 32'(k * 4);
  endfunction

  // monitor: samples on the falling edge
  int mon_total = 0, mon_bad = 0;
  int cyc = 0, bi = 0, bo = 0, ni = 0, no = 0, di = 0, d_out = 0;
  int last_i = -10, last_o = -10, wrem = 0;
  logic [31:0] wa = '0, gw = '0, h_addr = '0;
  logic [7:0]  h_len = '0;
  bit          h_on = 1'b0;

  task automatic mchk(input bit ok, input string tag, input longint act, input longint exp);
    mon_total++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (arm) begin
      bi = 0; bo = 0; ni = 0; no = 0; di = 0; d_out = 0; last_i = -10; last_o = -10;
    end else if (rst_n) begin
      if (h_on) mchk(ar_valid && ar_addr == h_addr && ar_len == h_len, "R6 stalled read request", longint'(ar_addr), longint'(h_addr));
      h_on = ar_valid && !ar_ready; h_addr = ar_addr; h_len = ar_len;
      if (ar_valid && ar_ready) begin
        bi++;
        mchk(int'(ar_addr[11:0]) + (int'(ar_len) + 1) * 4 <= 4096, "R5 read page edge", longint'(ar_addr), longint'(ar_len));
      end
      if (m_valid && m_ready) begin
        mchk(m_data == ea(ni), exp_wrap ? "R1 R4 stream data" : "R1 R3 stream data", longint'(m_data), longint'(ea(ni)));
        ni++; last_i = cyc;
      end
      if (aw_valid && aw_ready) begin
        bo++; wa = aw_addr; wrem = int'(aw_len) + 1;
        mchk(int'(aw_addr[11:0]) + wrem * 4 <= 4096, "R5 write page edge", longint'(aw_addr), longint'(aw_len));
      end
      if (w_valid && w_ready) begin
        mchk(wa == ea(no), exp_wrap ? "R2 R4 write addr" : "R2 R3 write addr", longint'(wa), longint'(ea(no)));
        mchk(w_data == gw, "R2 write data order", longint'(w_data), longint'(gw));
        mchk(w_last == (wrem == 1), "R2 w_last", longint'(w_last), longint'(wrem == 1));
        wa = wa + 32'd4; wrem--; no++; gw = gw + 32'd1;
      end
      if (b_valid && b_ready) last_o = cyc;
      if (done_i) begin
        di++;
        if (ni > 0) mchk(cyc == last_i + 1, "R8 read done timing", cyc, last_i + 1);
      end
      if (done_o) begin
        d_out++;
        if (no > 0) mchk(cyc == last_o + 1, "R8 write done timing", cyc, last_o + 1);
      end
    end
  end

  // stimulus and end-of-run checks
  int tb_total = 0, tb_bad = 0, wd_bad = 0;

  task automatic tchk(input bit ok, input string tag, input longint act, input longint exp);
    tb_total++;
    if (!ok) begin
      tb_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", tb_total + mon_total + wd_bad, tb_bad + mon_bad + wd_bad);
    $finish;
  endtask

  task automatic run(input logic [31:0] b, input int nb, input int nr, input bit wr,
                     input int expb, input bit poke);
    int t = 0;
    exp_base = b; exp_beats = nb; exp_wrap = wr;
    cfg_base = b; cfg_beats = 16'(nb); cfg_reps = 16'(nr); cfg_wrap = wr;
    start = 1'b1; arm = 1'b1;
    tick;
    start = 1'b0; arm = 1'b0;
    if (poke) begin
      repeat (5) tick;
      cfg_base = 32'h9000; cfg_beats = 16'd3; cfg_reps = 16'd1; cfg_wrap = 1'b0;
      start = 1'b1;
      tick;
      start = 1'b0;
    end
    while (!(di > 0 && d_out > 0)) begin
      tick; t++;
      if (t > 40000) begin
        tb_total++; tb_bad++;
        $display("FAIL R8 run never finished actual=%0d expected=1", di);
        finish_up;
      end
    end
    repeat (3) tick;
    tchk(bi == expb, poke ? "R10 read bursts" : "R5 read bursts", bi, expb);
    tchk(bo == expb, poke ? "R10 write bursts" : "R5 write bursts", bo, expb);
    tchk(ni == nb * nr, "R7 read beats", ni, nb * nr);
    tchk(no == nb * nr, "R7 written beats", no, nb * nr);
    tchk(di == 1, "R8 read done count", di, 1);
    tchk(d_out == 1, "R8 write done count", d_out, 1);
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R11
    tchk(!ar_valid && !aw_valid && !m_valid && !w_valid, "R11 valids after reset", ar_valid, 0);
    tchk(!done_i && !done_o && !s_ready, "R11 done after reset", done_i, 0);
    for (int v = 0; v < NV; v++)
      run(T_BASE[v], T_BEATS[v], T_REPS[v], T_WRAP[v], T_BURSTS[v], 1'b0);
    // R10: start during a run
    run(32'h7000, 40, 2, 1'b1, 2, 1'b1);
    // R9: zero images, then zero beats
    for (int z = 0; z < 2; z++) begin
      cfg_base = 32'h3000; cfg_beats = (z == 0) ? 16'd5 : 16'd0; cfg_reps = (z == 0) ? 16'd0 : 16'd3;
      start = 1'b1; arm = 1'b1;
      tick;
      tchk(done_i && done_o, "R9 empty run done", done_i, 1);
      tchk(!ar_valid && !aw_valid, "R9 empty run no request", ar_valid, 0);
      start = 1'b0; arm = 1'b0;
      tick;
      tchk(!done_i && !done_o, "R8 done one cycle", done_i, 0);
      repeat (3) tick;
      tchk(bi == 0 && bo == 0, "R9 no bursts", bi + bo, 0);
    end
    finish_up;
  end

  initial begin
    repeat (190000) @(posedge clk);
    wd_bad = 1;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up;
  end
endmodule